// File: doc/BRIEF.md
# Eviction-Fed Direct-Mapped Line Store

This block is a direct-mapped store of 32-byte lines that sits beside a snooping bus agent. Lines enter it only when a processor writes back a dirty line it has evicted; ordinary reads never allocate. When the transaction tracker sees another agent issue a full-line read, it presents the line address on the lookup port. The store answers hit or miss one cycle later, so the answer is ready in time for the snoop phase. On a hit it then plays the stored line back as four 64-bit beats for a cache-to-cache transfer.

Ownership-acquiring reads cause the tracker to pulse the invalidate port, which drops the matching line. A zero-length upgrade and a full-line read-with-invalidate are handled the same way. Capacity is a parameter from 1 KB to 256 KB. Because each address maps to exactly one entry, a new write-back simply displaces whatever occupied its index.

All addresses on the ports are line addresses: bits 35 down to 5 of the byte address, 31 bits wide. Bit 0 of a port address is byte-address bit 5.

Top module: `vls_line_store`

## Requirements
- R1: While reset is low, and after it is released, every entry is invalid, `lk_done` and `xfer_valid` are 0, and a lookup misses until a line has been written back.
- R2: A lookup presented with `lk_valid` in one cycle is answered in the next cycle with `lk_done`=1 and `lk_hit`=1 exactly when the indexed entry is valid and its stored tag equals the address tag; `lk_done` is 0 in every cycle that does not follow a lookup.
- R3: Only write-backs allocate. A line becomes valid when its beat with index 3 is written, and a lookup that misses leaves the store unchanged, so a repeated lookup misses again.
- R4: On a hit, `xfer_valid` is high for exactly four cycles, starting in the cycle that shows `lk_hit`. `xfer_beat` counts 0,1,2,3 across those cycles, and `xfer_data` is the write-back beat of the same index. A miss starts no transfer.
- R5: A write-back to an index that already holds a line with another tag replaces it; the old address then misses and the new one hits.
- R6: An invalidate whose tag matches a valid entry clears it. An invalidate whose tag differs leaves the stored line valid and readable. Other indices are never affected.
- R7: If the committing beat (index 3) of a write-back and an invalidate address the same index in the same cycle, the entry ends invalid, whatever the invalidate's tag.
- R8: Writing beat index 0 of a write-back clears the valid bit of its entry, so a lookup between beat 0 and beat 3 misses.
- R9: A lookup in the same cycle as a write-back commit or an invalidate sees the store as it was before that cycle. This applies to both the hit flag and the data it streams.
- R10: The index is the low log2(lines) bits of the line address and the tag is the remaining upper bits. With the default 1 KB (32 lines), addresses 0x12 and 0x32 share index 18 and displace each other.
- R11: A hit that arrives while a transfer is running restarts the transfer at beat 0 with the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | One write-back beat is present this cycle |
| wb_laddr | input | 31 | Line address of the write-back |
| wb_beat | input | 2 | Beat index 0..3 of the write-back beat |
| wb_data | input | 64 | Write-back beat data |
| lk_valid | input | 1 | Lookup request for a snooped full-line read |
| lk_laddr | input | 31 | Line address to look up |
| lk_done | output | 1 | Lookup answer present (one cycle after request) |
| lk_hit | output | 1 | Lookup found a valid matching line |
| xfer_valid | output | 1 | Transfer beat present |
| xfer_beat | output | 2 | Index of the transfer beat |
| xfer_data | output | 64 | Transfer beat data |
| inv_valid | input | 1 | Invalidate request from a read-with-invalidate |
| inv_laddr | input | 31 | Line address to invalidate |

## Verification
The write-back commit and the invalidate can both target one entry in the same clock. The bench provokes this by driving beat 3 of a write-back together with an invalidate of the same index, once with the same tag and once with a different tag. Both cases are judged by a following lookup, which must miss. A lookup can also coincide with a commit or an invalidate; there the bench checks that the answer and the streamed beats reflect the state before that edge.

// File: rtl/vls_pkg.sv
// Shared constants and types for the eviction-fed line store.
// Assumes 32-byte lines carried as four 64-bit beats and a 36-bit byte
// address, so a line address is 31 bits wide.
package vls_pkg;
    localparam int LADDR_W    = 31;
    localparam int LINE_BYTES = 32;
    localparam int BEAT_W     = 64;
    localparam int BEATS      = 4;
    localparam int BEAT_IDX_W = $clog2(BEATS);

    typedef logic [BEAT_W-1:0] beat_t;
    typedef beat_t [BEATS-1:0] line_t;
endpackage

// File: rtl/vls_tag_store.sv
// Valid bits and tags for every entry, with the lookup compare.
// Assumes LINES is a power of two. A beat-0 write clears an entry, a
// commit sets it, and an invalidate on the same index as a commit wins.
module vls_tag_store #(
    parameter int LINES = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             open_en,
    input  logic [IDX_W-1:0] open_idx,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar gi = 0; gi < LINES; gi++) begin : g_entry
        logic             sel_open;
        logic             sel_commit;
        logic             sel_inv;
        logic             valid_r;
        logic [TAG_W-1:0] tag_r;

        // Decode which requests address this entry.
        always_comb begin
            sel_open   = open_en   && (open_idx   == IDX_W'(gi));
            sel_commit = commit_en && (commit_idx == IDX_W'(gi));
            sel_inv    = inv_en    && (inv_idx    == IDX_W'(gi));
        end

        // Valid bit update with invalidate-over-commit priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_r <= 1'b0;
            end else if (sel_inv && sel_commit) begin
                valid_r <= 1'b0;
            end else if (sel_commit) begin
                valid_r <= 1'b1;
            end else if (sel_open) begin
                valid_r <= 1'b0;
            end else if (sel_inv && (tag_r == inv_tag)) begin
                valid_r <= 1'b0;
            end
        end

        // Tag capture on commit; the valid bit guards stale contents.
        always_ff @(posedge clk) begin
            if (sel_commit) begin
                tag_r <= commit_tag;
            end
        end

        assign valid_q[gi] = valid_r;
        assign tag_q[gi]   = tag_r;
    end

    // Lookup compare against the current (pre-edge) state.
    always_comb begin
        lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end
endmodule

// File: rtl/vls_data_store.sv
// Beat-addressed data array holding one line per entry.
// Assumes LINES is a power of two; write-back beats land in place, and the
// whole line at the lookup index is read out without a register.
module vls_data_store
    import vls_pkg::*;
#(
    parameter int LINES = 32,
    parameter int IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [BEAT_IDX_W-1:0] wr_beat,
    input  beat_t                 wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output line_t                 rd_line
);
    beat_t mem_q [LINES][BEATS];

    // Store one write-back beat.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx][wr_beat] <= wr_data;
        end
    end

    // Present the full line at the read index.
    always_comb begin
        for (int b = 0; b < BEATS; b++) begin
            rd_line[b] = mem_q[rd_idx][b];
        end
    end
endmodule

// File: rtl/vls_xfer_unit.sv
// Cache-to-cache transfer sequencer.
// Snapshots the hit line into a buffer and plays it out one beat per cycle;
// a new start while busy restarts from beat 0 with the new line.
module vls_xfer_unit
    import vls_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  line_t                 line_in,
    output logic                  xfer_valid,
    output logic [BEAT_IDX_W-1:0] xfer_beat,
    output beat_t                 xfer_data
);
    line_t                 buf_q;
    logic                  active_q;
    logic [BEAT_IDX_W-1:0] cnt_q;

    // Sequence state: active flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == BEAT_IDX_W'(BEATS - 1)) begin
                active_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Line snapshot taken at the start of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (start) begin
            buf_q <= line_in;
        end
    end

    assign xfer_valid = active_q;
    assign xfer_beat  = cnt_q;
    assign xfer_data  = buf_q[cnt_q];
endmodule

// File: rtl/vls_line_store.sv
// Top of the eviction-fed direct-mapped line store.
// Splits line addresses into index and tag, routes write-back beats to the
// data and tag stores, registers the lookup answer one cycle after the
// request and launches a four-beat transfer on a hit.
module vls_line_store
    import vls_pkg::*;
#(
    parameter int CAP_BYTES = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_valid,
    input  logic [LADDR_W-1:0]    wb_laddr,
    input  logic [BEAT_IDX_W-1:0] wb_beat,
    input  logic [BEAT_W-1:0]     wb_data,
    input  logic                  lk_valid,
    input  logic [LADDR_W-1:0]    lk_laddr,
    output logic                  lk_done,
    output logic                  lk_hit,
    output logic                  xfer_valid,
    output logic [BEAT_IDX_W-1:0] xfer_beat,
    output logic [BEAT_W-1:0]     xfer_data,
    input  logic                  inv_valid,
    input  logic [LADDR_W-1:0]    inv_laddr
);
    localparam int LINES = CAP_BYTES / LINE_BYTES;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = LADDR_W - IDX_W;

    logic [IDX_W-1:0] wb_idx, lk_idx, inv_idx;
    logic [TAG_W-1:0] wb_tag, lk_tag, inv_tag;
    logic             wb_open, wb_commit;
    logic             hit_c;
    line_t            rd_line;
    logic             lk_done_q, lk_hit_q;

    // Address split into index (low bits) and tag (upper bits).
    always_comb begin
        wb_idx  = wb_laddr[IDX_W-1:0];
        wb_tag  = wb_laddr[LADDR_W-1:IDX_W];
        lk_idx  = lk_laddr[IDX_W-1:0];
        lk_tag  = lk_laddr[LADDR_W-1:IDX_W];
        inv_idx = inv_laddr[IDX_W-1:0];
        inv_tag = inv_laddr[LADDR_W-1:IDX_W];
    end

    // Write-back phase decode: first beat opens, last beat commits.
    always_comb begin
        wb_open   = wb_valid && (wb_beat == '0);
        wb_commit = wb_valid && (wb_beat == BEAT_IDX_W'(BEATS - 1));
    end

    vls_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .lk_hit     (hit_c),
        .open_en    (wb_open),
        .open_idx   (wb_idx),
        .commit_en  (wb_commit),
        .commit_idx (wb_idx),
        .commit_tag (wb_tag),
        .inv_en     (inv_valid),
        .inv_idx    (inv_idx),
        .inv_tag    (inv_tag)
    );

    vls_data_store #(
        .LINES (LINES),
        .IDX_W (IDX_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (wb_valid),
        .wr_idx  (wb_idx),
        .wr_beat (wb_beat),
        .wr_data (wb_data),
        .rd_idx  (lk_idx),
        .rd_line (rd_line)
    );

    // Registered lookup answer, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done_q <= 1'b0;
            lk_hit_q  <= 1'b0;
        end else begin
            lk_done_q <= lk_valid;
            lk_hit_q  <= lk_valid && hit_c;
        end
    end

    vls_xfer_unit u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (lk_valid && hit_c),
        .line_in    (rd_line),
        .xfer_valid (xfer_valid),
        .xfer_beat  (xfer_beat),
        .xfer_data  (xfer_data)
    );

    assign lk_done = lk_done_q;
    assign lk_hit  = lk_hit_q;
endmodule

// File: rtl/vls_line_store_chk.sv
// Protocol checker for the line store's lookup and transfer ports.
// Observes only top-level ports; attached to every instance by bind.
module vls_line_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       lk_done,
    input logic       lk_hit,
    input logic       xfer_valid,
    input logic [1:0] xfer_beat
);
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done); // R2
    AST_NO_DONE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done); // R2
    AST_HIT_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_done); // R2
    AST_HIT_STARTS_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (xfer_valid && xfer_beat == 2'd0)); // R4
    AST_MISS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> !(xfer_valid && xfer_beat == 2'd0)); // R4
    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_beat != 2'd3) |=>
            (xfer_valid && (lk_hit || xfer_beat == $past(xfer_beat) + 2'd1))); // R4
    AST_STREAM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_beat == 2'd3) |=> (!xfer_valid || lk_hit)); // R4
    AST_NO_SPONTANEOUS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> (!xfer_valid || lk_hit)); // R4
    AST_RESTART_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && lk_hit) |-> xfer_beat == 2'd0); // R11
endmodule

bind vls_line_store vls_line_store_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_done    (lk_done),
    .lk_hit     (lk_hit),
    .xfer_valid (xfer_valid),
    .xfer_beat  (xfer_beat)
);

// File: tb/vls_line_store_bench.sv
`timescale 1ns/1ps
module vls_line_store_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wb_valid;
    logic [30:0] wb_laddr;
    logic [1:0]  wb_beat;
    logic [63:0] wb_data;
    logic        lk_valid;
    logic [30:0] lk_laddr;
    logic        lk_done;
    logic        lk_hit;
    logic        xfer_valid;
    logic [1:0]  xfer_beat;
    logic [63:0] xfer_data;
    logic        inv_valid;
    logic [30:0] inv_laddr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vls_line_store u_vls_line_store (
        .clk(clk), .rst_n(rst_n),
        .wb_valid(wb_valid), .wb_laddr(wb_laddr), .wb_beat(wb_beat), .wb_data(wb_data),
        .lk_valid(lk_valid), .lk_laddr(lk_laddr), .lk_done(lk_done), .lk_hit(lk_hit),
        .xfer_valid(xfer_valid), .xfer_beat(xfer_beat), .xfer_data(xfer_data),
        .inv_valid(inv_valid), .inv_laddr(inv_laddr)
    );

    // Addresses: A and B share index 18 (R10), C and D are distinct indices.
    localparam logic [30:0] LA = 31'h12;
    localparam logic [30:0] LB = 31'h32;
    localparam logic [30:0] LC = 31'h07;
    localparam logic [30:0] LD = 31'h05;

    localparam logic [1:0] OP_WB  = 2'd0;
    localparam logic [1:0] OP_LK  = 2'd1;
    localparam logic [1:0] OP_INV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [30:0] laddr;
        logic [7:0]  salt;
        logic        hit;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{OP_LK,  LA, 8'd0,  1'b0},  // R1 empty after reset
        '{OP_LK,  LA, 8'd0,  1'b0},  // R3 a missed lookup did not allocate
        '{OP_WB,  LA, 8'd11, 1'b0},
        '{OP_LK,  LA, 8'd11, 1'b1},  // R3 R4 filled by write-back
        '{OP_LK,  LC, 8'd0,  1'b0},  // R10 other index empty
        '{OP_WB,  LC, 8'd22, 1'b0},
        '{OP_LK,  LC, 8'd22, 1'b1},
        '{OP_WB,  LB, 8'd33, 1'b0},  // R5 R10 displaces A
        '{OP_LK,  LA, 8'd0,  1'b0},  // R5
        '{OP_LK,  LB, 8'd33, 1'b1},  // R5
        '{OP_INV, LA, 8'd0,  1'b0},  // R6 tag mismatch
        '{OP_LK,  LB, 8'd33, 1'b1},  // R6 still there
        '{OP_INV, LB, 8'd0,  1'b0},  // R6 tag match
        '{OP_LK,  LB, 8'd0,  1'b0},  // R6 gone
        '{OP_LK,  LC, 8'd22, 1'b1}   // R6 neighbour untouched
    };

    function automatic logic [63:0] pat(input logic [30:0] la, input logic [7:0] s,
                                        input logic [1:0] b);
        return {s, 1'b0, la, 22'h0, b};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_beat(input logic [30:0] la, input logic [7:0] s, input logic [1:0] b);
        wb_valid = 1'b1; wb_laddr = la; wb_beat = b; wb_data = pat(la, s, b);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic put_line(input logic [30:0] la, input logic [7:0] s);
        for (int b = 0; b < 4; b++) put_beat(la, s, 2'(b));
    endtask

    task automatic do_inv(input logic [30:0] la);
        inv_valid = 1'b1; inv_laddr = la;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // Check four beats of a stream whose beat 0 is visible now.
    task automatic drain(input logic [30:0] la, input logic [7:0] s, input string req);
        for (int b = 0; b < 4; b++) begin
            chk(xfer_valid && xfer_beat == 2'(b) && xfer_data == pat(la, s, 2'(b)), req,
                xfer_data, pat(la, s, 2'(b)));
            @(negedge clk);
        end
        chk(!xfer_valid, req, 64'(xfer_valid), 64'd0);
    endtask

    task automatic probe(input logic [30:0] la, input logic exp_hit, input logic [7:0] s,
                         input string req);
        lk_valid = 1'b1; lk_laddr = la;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(lk_done == 1'b1, "R2 answer timing", 64'(lk_done), 64'd1);
        chk(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) drain(la, s, "R4 beats");
        else chk(!xfer_valid, "R4 no transfer on miss", 64'(xfer_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wb_valid = 1'b0; lk_valid = 1'b0; inv_valid = 1'b0;
        wb_laddr = '0; wb_beat = '0; wb_data = '0; lk_laddr = '0; inv_laddr = '0;
        repeat (3) @(negedge clk);
        chk(!lk_done && !xfer_valid, "R1 reset outputs", {lk_done, xfer_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WB:   put_line(VEC[i].laddr, VEC[i].salt);
                OP_INV:  do_inv(VEC[i].laddr);
                default: probe(VEC[i].laddr, VEC[i].hit, VEC[i].salt, "R2 R3 R5 R6 R10 table hit");
            endcase
        end

        // R7: commit and matching invalidate in one cycle.
        for (int b = 0; b < 3; b++) put_beat(LA, 8'd66, 2'(b));
        wb_valid = 1'b1; wb_laddr = LA; wb_beat = 2'd3; wb_data = pat(LA, 8'd66, 2'd3);
        inv_valid = 1'b1; inv_laddr = LA;
        @(negedge clk);
        wb_valid = 1'b0; inv_valid = 1'b0;
        probe(LA, 1'b0, 8'd0, "R7 same tag");
        // R7: commit and other-tag invalidate on the same index.
        for (int b = 0; b < 3; b++) put_beat(LA, 8'd67, 2'(b));
        wb_valid = 1'b1; wb_laddr = LA; wb_beat = 2'd3; wb_data = pat(LA, 8'd67, 2'd3);
        inv_valid = 1'b1; inv_laddr = LB;
        @(negedge clk);
        wb_valid = 1'b0; inv_valid = 1'b0;
        probe(LA, 1'b0, 8'd0, "R7 other tag");
        put_line(LA, 8'd68);
        probe(LA, 1'b1, 8'd68, "R3 refill");

        // R8: beat 0 opens the entry and hides the old line.
        put_beat(LC, 8'd44, 2'd0);
        probe(LC, 1'b0, 8'd0, "R8 partial refill");
        for (int b = 1; b < 4; b++) put_beat(LC, 8'd44, 2'(b));
        probe(LC, 1'b1, 8'd44, "R8 refill done");

        // R9: lookup in the commit cycle sees the old state.
        for (int b = 0; b < 3; b++) put_beat(LD, 8'd55, 2'(b));
        wb_valid = 1'b1; wb_laddr = LD; wb_beat = 2'd3; wb_data = pat(LD, 8'd55, 2'd3);
        lk_valid = 1'b1; lk_laddr = LD;
        @(negedge clk);
        wb_valid = 1'b0; lk_valid = 1'b0;
        chk(lk_done && !lk_hit, "R9 lookup with commit", {lk_done, lk_hit}, 64'd2);
        probe(LD, 1'b1, 8'd55, "R9 after commit");
        // R9: lookup in the invalidate cycle still hits and streams.
        lk_valid = 1'b1; lk_laddr = LC; inv_valid = 1'b1; inv_laddr = LC;
        @(negedge clk);
        lk_valid = 1'b0; inv_valid = 1'b0;
        chk(lk_hit == 1'b1, "R9 lookup with invalidate", 64'(lk_hit), 64'd1);
        drain(LC, 8'd44, "R9 data with invalidate");
        probe(LC, 1'b0, 8'd0, "R6 after invalidate");

        // R11: a second hit mid-transfer restarts the stream.
        lk_valid = 1'b1; lk_laddr = LA;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(xfer_valid && xfer_beat == 2'd0 && xfer_data == pat(LA, 8'd68, 2'd0),
            "R11 first line beat 0", xfer_data, pat(LA, 8'd68, 2'd0));
        lk_valid = 1'b1; lk_laddr = LD;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(lk_hit == 1'b1, "R11 second hit", 64'(lk_hit), 64'd1);
        drain(LD, 8'd55, "R11 restarted stream");

        // R1: reset again clears everything.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!lk_done && !xfer_valid, "R1 reset outputs again", {lk_done, xfer_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        probe(LD, 1'b0, 8'd0, "R1 empty after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule